// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Macrocell

This block is one logic cell of an erasable programmable logic device. It reads a few input literals and a static configuration word. From these it forms eight programmable AND terms and ORs them into one sum. An optional inversion sets the polarity. The result can drive the pin directly. It can also be captured in a storage element that works as either a D or a T flip-flop, on a rising or a falling edge.

Two extra AND terms control the storage element. One is an auxiliary term. In synchronous mode it gates the output enable and the global clock runs the flop. In asynchronous mode it becomes the flop's clock and the output enable is held on. The other is a clear term that resets the flop at once. A feedback selector returns either the flop state or the pad's input value to the array as one more literal. The output driver is modelled as a data bit plus an enable flag.

Top module: `mc_macrocell`

## Requirements
- R1: Every AND term reads 2 bits per literal. Literal j sits at bits [2j+1:2j] of the term's mask. Code 00 ignores the literal, 01 needs the literal at 1, 10 needs it at 0, and 11 forces the term to 0. A term with every literal at code 00 is 1. The literal vector is {feedback, lit_i}, so the feedback literal has index N_IN.
- R2: The cfg word holds the mask of sum term k at [k*2L +: 2L], where L = N_IN+1. Above these sit N_SUM enable bits. The sum is the OR of the enabled terms only. A disabled term adds 0, so with no term enabled the sum is 0.
- R3: Control bit 1 (invert) complements the sum. This complemented value is the data value.
- R4: When control bit 5 (registered output) is 0, pin_o equals the data value, with no clock delay.
- R5: With control bit 2 at 0, the flop loads the data value on its active edge. When control bit 5 is 1, pin_o shows the flop state.
- R6: With control bit 2 at 1, the flop XORs its state with the data value on each active edge.
- R7: When control bit 3 is 1, the active edge is the falling edge of the selected clock. Otherwise it is the rising edge.
- R8: When control bit 4 is 0 (synchronous mode), the flop runs on gclk and pin_oe equals the auxiliary term. The auxiliary term's mask sits just above the enable bits.
- R9: When control bit 4 is 1 (asynchronous mode), the auxiliary term clocks the flop, gclk has no effect on it, and pin_oe is 1.
- R10: The clear term's mask lies above the auxiliary mask, and control bit 0 enables it. The control bits follow the clear mask. While the enabled clear term is 1, or rst is 1, the flop is 0 at once, whatever the clock does.
- R11: When control bit 6 is 0, the feedback literal is the flop state. When it is 1, the feedback literal is pad_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global clock |
| rst | input | 1 | Active-high reset, acts through the clear path |
| cfg | input | N_SUM*2L+N_SUM+4L+7 | Static configuration word |
| lit_i | input | N_IN | Input literals |
| pad_i | input | 1 | Value read back from the pad |
| pin_o | output | 1 | Output data |
| pin_oe | output | 1 | Output enable |

## Verification
The flop is the only state that matters. If it holds a wrong value, the error reaches pin_o within a quarter to a full clock in registered output mode. Through the feedback literal, it shifts the data value and the auxiliary term in every mode. The reference model mirrors the flop from the requirements. It compares pin_o and pin_oe once per cycle, just before the next rising edge. A wrong edge, a missed clear or a swapped D/T rule therefore appears one sample later. In asynchronous runs, data literals and the clock literal are changed in separate cycles, so the capture is well defined.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    LIT_ANY = 2'b00,
    LIT_POS = 2'b01,
    LIT_NEG = 2'b10,
    LIT_OFF = 2'b11
  } lit_use_e;

  localparam int CTRL_BITS = 7;

  // packed: first member is the MSB (bit 6), clr_en is bit 0
  typedef struct packed {
    logic fb_pad;
    logic reg_out;
    logic async_clk;
    logic neg_edge;
    logic t_mode;
    logic invert;
    logic clr_en;
  } ctrl_t;

endpackage

// File: rtl/mc_pterm.sv
module mc_pterm #(
  parameter int N_LIT = 5
) (
  input  logic [2*N_LIT-1:0] mask,
  input  logic [N_LIT-1:0]   lit,
  output logic               term
);
  import mc_pkg::*;

  logic [N_LIT-1:0] ok;

  for (genvar j = 0; j < N_LIT; j++) begin : g_lit
    lit_use_e code;
    assign code  = lit_use_e'(mask[2*j +: 2]);
    assign ok[j] = (code == LIT_ANY) |
                   ((code == LIT_POS) &  lit[j]) |
                   ((code == LIT_NEG) & ~lit[j]);
  end

  assign term = &ok;

endmodule

// File: rtl/mc_or_plane.sv
module mc_or_plane #(
  parameter int N_LIT   = 5,
  parameter int N_TERMS = 8
) (
  input  logic [N_TERMS*2*N_LIT-1:0] masks,
  input  logic [N_TERMS-1:0]         en,
  input  logic [N_LIT-1:0]           lit,
  input  logic                       invert,
  output logic                       sum_pol
);
  localparam int MW = 2 * N_LIT;

  logic [N_TERMS-1:0] terms;

  for (genvar k = 0; k < N_TERMS; k++) begin : g_term
    mc_pterm #(.N_LIT(N_LIT)) u_pt (
      .mask (masks[k*MW +: MW]),
      .lit  (lit),
      .term (terms[k])
    );
  end

  assign sum_pol = (|(terms & en)) ^ invert;

endmodule

// File: rtl/mc_storage.sv
module mc_storage (
  input  logic gclk,
  input  logic aux_clk,
  input  logic async_sel,
  input  logic neg_edge,
  input  logic t_mode,
  input  logic d,
  input  logic clr,
  output logic q
);
  logic ck_sel;
  logic ck_eff;

  assign ck_sel = async_sel ? aux_clk : gclk;
  assign ck_eff = ck_sel ^ neg_edge;

  always_ff @(posedge ck_eff or posedge clr) begin
    if (clr)         q <= 1'b0;
    else if (t_mode) q <= q ^ d;
    else             q <= d;
  end

endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell #(
  parameter int N_IN  = 4,
  parameter int N_SUM = 8
) (
  input  logic gclk,
  input  logic rst,
  input  logic [N_SUM*2*(N_IN+1) + N_SUM + 4*(N_IN+1) + mc_pkg::CTRL_BITS - 1:0] cfg,
  input  logic [N_IN-1:0] lit_i,
  input  logic pad_i,
  output logic pin_o,
  output logic pin_oe
);
  import mc_pkg::*;

  localparam int L        = N_IN + 1;
  localparam int MW       = 2 * L;
  localparam int OFF_EN   = N_SUM * MW;
  localparam int OFF_AUX  = OFF_EN + N_SUM;
  localparam int OFF_CLR  = OFF_AUX + MW;
  localparam int OFF_CTRL = OFF_CLR + MW;

  ctrl_t          ctrl;
  logic [N_SUM-1:0] sum_en;
  logic [L-1:0]   lits;
  logic           fb_lit;
  logic           ff_q;
  logic           d_pol;
  logic           aux_term;
  logic           clr_term;
  logic           clr_act;

  assign ctrl   = ctrl_t'(cfg[OFF_CTRL +: CTRL_BITS]);
  assign sum_en = cfg[OFF_EN +: N_SUM];

  assign fb_lit = ctrl.fb_pad ? pad_i : ff_q;
  assign lits   = {fb_lit, lit_i};

  mc_or_plane #(.N_LIT(L), .N_TERMS(N_SUM)) u_plane (
    .masks   (cfg[OFF_EN-1:0]),
    .en      (sum_en),
    .lit     (lits),
    .invert  (ctrl.invert),
    .sum_pol (d_pol)
  );

  mc_pterm #(.N_LIT(L)) u_aux (
    .mask (cfg[OFF_AUX +: MW]),
    .lit  (lits),
    .term (aux_term)
  );

  mc_pterm #(.N_LIT(L)) u_clr (
    .mask (cfg[OFF_CLR +: MW]),
    .lit  (lits),
    .term (clr_term)
  );

  assign clr_act = rst | (ctrl.clr_en & clr_term);

  mc_storage u_ff (
    .gclk      (gclk),
    .aux_clk   (aux_term),
    .async_sel (ctrl.async_clk),
    .neg_edge  (ctrl.neg_edge),
    .t_mode    (ctrl.t_mode),
    .d         (d_pol),
    .clr       (clr_act),
    .q         (ff_q)
  );

  assign pin_o  = ctrl.reg_out ? ff_q : d_pol;
  assign pin_oe = ctrl.async_clk | aux_term;

endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk #(
  parameter int N_SUM = 8
) (
  input logic             gclk,
  input logic             rst,
  input logic [6:0]       ctrl_raw,
  input logic [N_SUM-1:0] sum_en,
  input logic             d_pol,
  input logic             aux_term,
  input logic             clr_act,
  input logic             ff_q,
  input logic             pin_oe
);
  import mc_pkg::*;

  ctrl_t c;
  logic  d_sync;
  logic  t_sync;

  assign c      = ctrl_t'(ctrl_raw);
  assign d_sync = !c.async_clk && !c.neg_edge && !c.t_mode;
  assign t_sync = !c.async_clk && !c.neg_edge &&  c.t_mode;

  a_r8_oe_tracks_aux: assert property (@(posedge gclk) disable iff (rst)
    !c.async_clk |-> (pin_oe == aux_term));

  a_r9_oe_forced: assert property (@(posedge gclk) disable iff (rst)
    c.async_clk |-> pin_oe);

  a_r2_empty_sum: assert property (@(posedge gclk) disable iff (rst)
    (sum_en == '0) |-> (d_pol == c.invert));

  a_r10_clear_wins: assert property (@(posedge gclk) disable iff (rst)
    clr_act |-> !ff_q);

  a_r5_d_capture: assert property (@(posedge gclk) disable iff (rst)
    (!$past(rst) && $past(d_sync) && d_sync && !$past(clr_act) && !clr_act)
    |-> (ff_q == $past(d_pol)));

  a_r6_t_toggle: assert property (@(posedge gclk) disable iff (rst)
    (!$past(rst) && $past(t_sync) && t_sync && !$past(clr_act) && !clr_act)
    |-> (ff_q == ($past(ff_q) ^ $past(d_pol))));

endmodule

bind mc_macrocell mc_macrocell_chk #(.N_SUM(N_SUM)) u_chk (
  .gclk     (gclk),
  .rst      (rst),
  .ctrl_raw (ctrl),
  .sum_en   (sum_en),
  .d_pol    (d_pol),
  .aux_term (aux_term),
  .clr_act  (clr_act),
  .ff_q     (ff_q),
  .pin_oe   (pin_oe)
);

// File: tb/tb_mc_macrocell.sv
`timescale 1ns/1ps
module tb_mc_macrocell;
  localparam int N_IN     = 4;
  localparam int N_SUM    = 8;
  localparam int L        = N_IN + 1;
  localparam int MW       = 2 * L;
  localparam int OFF_EN   = N_SUM * MW;
  localparam int OFF_AUX  = OFF_EN + N_SUM;
  localparam int OFF_CLR  = OFF_AUX + MW;
  localparam int OFF_CTRL = OFF_CLR + MW;
  localparam int CFG_W    = OFF_CTRL + 7;
  localparam int T_AUX    = N_SUM;
  localparam int T_CLR    = N_SUM + 1;
  localparam int B_CLR = 0, B_INV = 1, B_TFF = 2, B_NEG = 3, B_ASY = 4, B_REG = 5, B_FBP = 6;

  logic gclk = 1'b0;
  logic rst = 1'b1;
  logic [CFG_W-1:0] cfg = '0;
  logic [CFG_W-1:0] nc = '0;
  logic [N_IN-1:0] lit = '0;
  logic pad = 1'b0;
  logic pin_o, pin_oe;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R10";

  always #2 gclk = ~gclk;

  mc_macrocell #(.N_IN(N_IN), .N_SUM(N_SUM)) dut (
    .gclk(gclk), .rst(rst), .cfg(cfg), .lit_i(lit), .pad_i(pad),
    .pin_o(pin_o), .pin_oe(pin_oe)
  );

  // ---------------- reference model ----------------
  function automatic logic term_of(input logic [MW-1:0] m, input logic [L-1:0] v);
    for (int j = 0; j < L; j++) begin
      logic [1:0] code = m[2*j +: 2];
      if (code == 2'b11) return 1'b0;
      if (code == 2'b01 && !v[j]) return 1'b0;
      if (code == 2'b10 &&  v[j]) return 1'b0;
    end
    return 1'b1;
  endfunction

  logic mq = 1'b0;
  logic m_fb, m_d, m_aux, m_clr, m_ck;
  logic [L-1:0] m_lits;

  always_comb begin
    logic s;
    m_fb   = cfg[OFF_CTRL+B_FBP] ? pad : mq;
    m_lits = {m_fb, lit};
    s = 1'b0;
    for (int k = 0; k < N_SUM; k++)
      if (cfg[OFF_EN+k] && term_of(cfg[k*MW +: MW], m_lits)) s = 1'b1;
    m_d   = s ^ cfg[OFF_CTRL+B_INV];
    m_aux = term_of(cfg[OFF_AUX +: MW], m_lits);
    m_clr = rst | (cfg[OFF_CTRL+B_CLR] & term_of(cfg[OFF_CLR +: MW], m_lits));
    m_ck  = (cfg[OFF_CTRL+B_ASY] ? m_aux : gclk) ^ cfg[OFF_CTRL+B_NEG];
  end

  always @(posedge m_ck or posedge m_clr) begin
    if (m_clr) mq <= 1'b0;
    else if (cfg[OFF_CTRL+B_TFF]) mq <= mq ^ m_d;
    else mq <= m_d;
  end

  // ---------------- checking ----------------
  task automatic chk(input logic act, input logic exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(posedge gclk) begin
    #3;
    if (!done) begin
      chk(pin_o,  cfg[OFF_CTRL+B_REG] ? mq : m_d, "pin_o");
      chk(pin_oe, cfg[OFF_CTRL+B_ASY] ? 1'b1 : m_aux, "pin_oe");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic set_use(input int t, input int j, input logic [1:0] code);
    int base = (t < N_SUM) ? t*MW : (t == T_AUX ? OFF_AUX : OFF_CLR);
    nc[base + 2*j +: 2] = code;
  endtask

  task automatic reconfig();
    @(posedge gclk); #1;
    rst = 1'b1;
    cfg = nc;
    @(posedge gclk); #1;
    rst = 1'b0;
  endtask

  task automatic drv(input logic [N_IN-1:0] v, input logic p);
    @(posedge gclk); #1;
    lit = v;
    pad = p;
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++) drv(N_IN'($urandom), 1'($urandom));
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge gclk);
    #1 rst = 1'b0;
    @(posedge gclk); #3;
    cur_req = "R2"; chk(pin_o, 1'b0, "reset pin_o, no term enabled");
    cur_req = "R8"; chk(pin_oe, 1'b1, "reset pin_oe, blank aux term");

    // R1: literal codes, forced-off term
    cur_req = "R1";
    nc = '0;
    set_use(0, 0, 2'b01); set_use(0, 1, 2'b10);
    set_use(1, 2, 2'b01); set_use(1, 3, 2'b01);
    set_use(2, 0, 2'b11);
    nc[OFF_EN +: N_SUM] = 8'b0000_0111;
    reconfig();
    for (int v = 0; v < 8; v++) drv(N_IN'(v), 1'b0);
    cur_req = "R4";
    for (int v = 8; v < 16; v++) drv(N_IN'(v), 1'b1);

    // R2: disabled terms contribute nothing
    cur_req = "R2";
    nc[OFF_EN +: N_SUM] = 8'b0000_0010;
    reconfig();
    for (int v = 0; v < 16; v++) drv(N_IN'(v), 1'b0);
    nc[OFF_EN +: N_SUM] = '0;
    reconfig();
    for (int v = 0; v < 4; v++) drv(N_IN'(v * 5), 1'b0);

    // R3: polarity
    cur_req = "R3";
    nc[OFF_EN +: N_SUM] = 8'b0000_0010;
    nc[OFF_CTRL+B_INV] = 1'b1;
    reconfig();
    for (int v = 0; v < 16; v++) drv(N_IN'(v), 1'b0);

    // R5: D flop, registered output
    cur_req = "R5";
    nc = '0;
    set_use(0, 0, 2'b01);
    nc[OFF_EN] = 1'b1;
    nc[OFF_CTRL+B_REG] = 1'b1;
    reconfig();
    rand_run(40);

    // R6: T flop
    cur_req = "R6";
    nc[OFF_CTRL+B_TFF] = 1'b1;
    reconfig();
    rand_run(40);

    // R7: falling edge
    cur_req = "R7";
    nc[OFF_CTRL+B_TFF] = 1'b0;
    nc[OFF_CTRL+B_NEG] = 1'b1;
    reconfig();
    rand_run(30);

    // R8: output enable from aux term
    cur_req = "R8";
    nc[OFF_CTRL+B_NEG] = 1'b0;
    set_use(T_AUX, 1, 2'b01);
    reconfig();
    rand_run(30);

    // R9: aux term as local clock on lit3; data on lit0
    cur_req = "R9";
    nc = '0;
    set_use(0, 0, 2'b01);
    nc[OFF_EN] = 1'b1;
    set_use(T_AUX, 3, 2'b01);
    nc[OFF_CTRL+B_REG] = 1'b1;
    nc[OFF_CTRL+B_ASY] = 1'b1;
    reconfig();
    for (int i = 0; i < 16; i++) begin
      logic [2:0] dv = 3'($urandom);
      drv({1'b0, dv}, 1'b0);
      drv({1'b0, dv}, 1'b0);
      drv({1'b1, dv}, 1'b0);
      drv({1'b1, dv}, 1'b0);
    end

    // R10: clear term on lit2 beats a constant-1 D input
    cur_req = "R10";
    nc = '0;
    nc[OFF_EN] = 1'b1;
    set_use(T_CLR, 2, 2'b01);
    nc[OFF_CTRL+B_CLR] = 1'b1;
    nc[OFF_CTRL+B_REG] = 1'b1;
    reconfig();
    for (int i = 0; i < 3; i++) drv(4'b0000, 1'b0);
    for (int i = 0; i < 3; i++) drv(4'b0100, 1'b0);
    for (int i = 0; i < 3; i++) drv(4'b0000, 1'b0);
    for (int i = 0; i < 2; i++) drv(4'b0100, 1'b0);
    drv(4'b1011, 1'b0);

    // R11: feedback from flop state, then from the pad
    cur_req = "R11";
    nc = '0;
    set_use(0, N_IN, 2'b10);
    nc[OFF_EN] = 1'b1;
    nc[OFF_CTRL+B_REG] = 1'b1;
    reconfig();
    rand_run(10);
    nc = '0;
    set_use(0, N_IN, 2'b01);
    nc[OFF_EN] = 1'b1;
    nc[OFF_CTRL+B_FBP] = 1'b1;
    reconfig();
    rand_run(12);

    @(posedge gclk); #4;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule